// File: doc/BRIEF.md
# Overlap-Save Input Buffer Controller

This block holds the input samples for an overlap-save block convolution. Complex samples (separate I and Q lanes) stream in through a valid/ready pair and are written into single-port block RAM. When a full block of samples is in the buffer, the block raises a block-ready flag. The downstream engine accepts the block with a start pulse and then reads the buffer through a read port with one cycle of latency.

While the engine reads the last `OVL` addresses of the buffer, the returned samples are also copied into a small register cache. When the engine signals that it is done, the controller enters a copy state. For `OVL` cycles it writes the cached tail back to buffer addresses `0..OVL-1`, one sample per cycle. The read port and the cache write-back never share the RAM port in the same cycle. Filling then resumes at address `OVL`, so the next block needs only `DEPTH-OVL` new samples. The cache index comes from an 8-bit copy counter that is zero-extended to form the buffer address.

Top module: `overlapSaveBuffer`

## Requirements
- R1: While reset is held, `inReady`, `blockReady` and `rdValid` are 0. After reset is released, the block spends one idle cycle and then raises `inReady`.
- R2: A sample is stored when `inValid` and `inReady` are both high at a clock edge. After reset, consecutive accepted samples go to buffer addresses 0, 1, 2 and onward.
- R3: `blockReady` rises in the cycle after the `DEPTH`-th sample is held, and not before. While it is high, `inReady` is 0 and any offered samples are not stored.
- R4: A `procStart` pulse while `blockReady` is high starts processing, and `blockReady` and `inReady` are 0 from the next cycle. A `procStart` at any other time has no effect.
- R5: During processing, `rdEn` with `rdAddr` gives `rdValid` = 1 and the stored I/Q sample one cycle later. `rdEn` outside processing gives no `rdValid`.
- R6: A sample read during processing from address `DEPTH-OVL+k` is kept as overlap sample `k` (k = 0..OVL-1).
- R7: `procDone` with `rdEn` low during processing starts the overlap copy. `inReady` stays 0 for exactly `OVL` cycles after that edge.
- R8: After the copy, addresses `0..OVL-1` hold the captured overlap samples. Filling resumes at address `OVL`, and `blockReady` rises after exactly `DEPTH-OVL` more samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample valid |
| inI | input | DW | Input sample, in-phase |
| inQ | input | DW | Input sample, quadrature |
| inReady | output | 1 | Buffer accepts a sample this cycle |
| blockReady | output | 1 | Full block held, waiting for start |
| procStart | input | 1 | Start processing the ready block |
| procDone | input | 1 | Processing finished, begin overlap copy |
| rdEn | input | 1 | Buffer read request (processing only) |
| rdAddr | input | AW | Buffer read address |
| rdValid | output | 1 | Read data valid, one cycle after `rdEn` |
| rdI | output | DW | Read data, in-phase |
| rdQ | output | DW | Read data, quadrature |

## Verification
A wrong fill pointer shows up at the ports within one block. `blockReady` then rises after the wrong number of samples, or the read-back contents are shifted. A fault in the cache or in the copy counter only appears in the next block, when addresses `0..OVL-1` are read back and differ from the tail of the previous block. A stuck or mis-sized copy state changes how many cycles `inReady` stays low right after `procDone`, so the bench can see it at that edge.

// File: rtl/osb_pkg.sv
package osb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROC = 2'd2,
    ST_COPY = 2'd3
  } osbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;      // write the RAM this cycle
    logic useCache;  // write data comes from the overlap cache
    logic rdEn;      // read the RAM this cycle
  } osbStrobe_t;
endpackage

// File: rtl/osbRam.sv
module osbRam #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wData,
  output logic [DW-1:0] rData
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[addr] <= wData;
    if (rdEn) rData <= mem[addr];
  end
endmodule

// File: rtl/osbCtrl.sv
module osbCtrl
  import osb_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int OVL   = 64,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(OVL)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  output logic          blockReady,
  input  logic          procStart,
  input  logic          procDone,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output osbStrobe_t    strb,
  output logic [AW-1:0] bufAddr,
  output logic [CW-1:0] cacheIdx
);
  localparam logic [AW:0]      FULL_PTR = (AW+1)'(DEPTH);
  localparam logic [AW:0]      OVL_PTR  = (AW+1)'(OVL);
  localparam logic [CNT_W-1:0] OVL_LAST = CNT_W'(OVL - 1);

  osbState_t        state;
  logic [AW:0]      wrPtr;
  logic [CNT_W-1:0] copyCnt;
  logic             accept;

  always_comb begin
    inReady       = (state == ST_FILL) && (wrPtr != FULL_PTR);
    blockReady    = (state == ST_FILL) && (wrPtr == FULL_PTR);
    accept        = inValid && inReady;
    strb.wrEn     = accept || (state == ST_COPY);
    strb.useCache = (state == ST_COPY);
    strb.rdEn     = (state == ST_PROC) && rdEn;
    cacheIdx      = copyCnt[CW-1:0];
    if (state == ST_COPY)      bufAddr = {{(AW-CNT_W){1'b0}}, copyCnt};
    else if (state == ST_PROC) bufAddr = rdAddr;
    else                       bufAddr = wrPtr[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wrPtr   <= '0;
      copyCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_FILL;
          wrPtr <= '0;
        end
        ST_FILL: begin
          if (accept) wrPtr <= wrPtr + 1'b1;
          if (blockReady && procStart) state <= ST_PROC;
        end
        ST_PROC: begin
          if (procDone && !rdEn) begin
            state   <= ST_COPY;
            copyCnt <= '0;
          end
        end
        ST_COPY: begin
          if (copyCnt == OVL_LAST) begin
            state <= ST_FILL;
            wrPtr <= OVL_PTR;
          end else begin
            copyCnt <= copyCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: block-ready only ever rises right after an accepted sample
  assert_ready_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blockReady) |-> $past(accept));
  // R4: a held block stays held until processing starts
  assert_block_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    blockReady |=> (blockReady || state == ST_PROC));
  // R7: done with no read in flight moves to the copy state
  assert_copy_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROC && procDone && !rdEn) |=> (state == ST_COPY && copyCnt == '0));
  // R8: the last copy step resumes filling just past the overlap
  assert_resume_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COPY && copyCnt == OVL_LAST) |=> (state == ST_FILL && wrPtr == OVL_PTR));
endmodule

// File: rtl/osbDatapath.sv
module osbDatapath
  import osb_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int OVL   = 64,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(OVL),
  localparam int TAIL_BASE = DEPTH - OVL
) (
  input  logic          clk,
  input  logic          rstN,
  input  osbStrobe_t    strb,
  input  logic [AW-1:0] bufAddr,
  input  logic [CW-1:0] cacheIdx,
  input  logic [DW-1:0] inI,
  input  logic [DW-1:0] inQ,
  output logic          rdValid,
  output logic [DW-1:0] rdI,
  output logic [DW-1:0] rdQ
);
  logic [AW-1:0] rdAddrQ;
  logic [CW-1:0] tailOff;
  logic          inTail;
  logic [DW-1:0] laneIn  [2];
  logic [DW-1:0] laneOut [2];

  assign laneIn[0] = inI;
  assign laneIn[1] = inQ;
  assign rdI = laneOut[0];
  assign rdQ = laneOut[1];
  assign tailOff = CW'(rdAddrQ - AW'(TAIL_BASE));
  assign inTail  = rdAddrQ >= AW'(TAIL_BASE);

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strb.rdEn;
    if (strb.rdEn) rdAddrQ <= bufAddr;
  end

  // one RAM and one overlap cache per lane
  for (genvar ln = 0; ln < 2; ln++) begin : gLane
    logic [DW-1:0] cache [OVL];
    logic [DW-1:0] wData;

    assign wData = strb.useCache ? cache[cacheIdx] : laneIn[ln];

    always_ff @(posedge clk) begin
      if (rdValid && inTail) cache[tailOff] <= laneOut[ln];
    end

    osbRam #(.DW(DW), .DEPTH(DEPTH)) uRam (
      .clk  (clk),
      .wrEn (strb.wrEn),
      .rdEn (strb.rdEn),
      .addr (bufAddr),
      .wData(wData),
      .rData(laneOut[ln])
    );
  end

  // R5: single RAM port, a read never shares a cycle with a write
  assert_port_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> !strb.rdEn);
  // R6: tail capture only happens with data returned by a processing read
  assert_capture_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && inTail) |-> $past(strb.rdEn));
endmodule

// File: rtl/overlapSaveBuffer.sv
module overlapSaveBuffer
  import osb_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int OVL   = 64,
  parameter int DW    = 16,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(OVL)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [DW-1:0] inI,
  input  logic [DW-1:0] inQ,
  output logic          inReady,
  output logic          blockReady,
  input  logic          procStart,
  input  logic          procDone,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic          rdValid,
  output logic [DW-1:0] rdI,
  output logic [DW-1:0] rdQ
);
  osbStrobe_t    strb;
  logic [AW-1:0] bufAddr;
  logic [CW-1:0] cacheIdx;

  osbCtrl #(.DEPTH(DEPTH), .OVL(OVL), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .blockReady(blockReady), .procStart(procStart), .procDone(procDone),
    .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb), .bufAddr(bufAddr),
    .cacheIdx(cacheIdx)
  );

  osbDatapath #(.DEPTH(DEPTH), .OVL(OVL), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .bufAddr(bufAddr),
    .cacheIdx(cacheIdx), .inI(inI), .inQ(inQ), .rdValid(rdValid),
    .rdI(rdI), .rdQ(rdQ)
  );
endmodule

// File: tb/tb_overlapSaveBuffer.sv
module tb_overlapSaveBuffer;
  localparam int DEPTH = 1024;
  localparam int OVL   = 64;
  localparam int DW    = 16;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rstN, inValid, procStart, procDone, rdEn;
  logic [DW-1:0] inI, inQ;
  logic [AW-1:0] rdAddr;
  logic          inReady, blockReady, rdValid;
  logic [DW-1:0] rdI, rdQ;

  overlapSaveBuffer dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .inReady(inReady), .blockReady(blockReady), .procStart(procStart),
    .procDone(procDone), .rdEn(rdEn), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdI(rdI), .rdQ(rdQ)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] expI [DEPTH];
  logic [DW-1:0] expQ [DEPTH];
  logic [DW-1:0] tailI [OVL];
  logic [DW-1:0] tailQ [OVL];
  int order [DEPTH];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // bench function: expected sample pattern for an address of a block
  function automatic logic [DW-1:0] pattern(input int blk, input int a, input bit q);
    return DW'((blk * 16'h1357) ^ (a * 16'h0b3d) ^ (q ? 16'h5a5a : 16'h0) ^ $urandom_range(0, 255));
  endfunction

  task automatic push(input int blk, input int a);
    repeat ($urandom_range(0, 2)) tick();
    inI = pattern(blk, a, 1'b0);
    inQ = pattern(blk, a, 1'b1);
    expI[a] = inI;
    expQ[a] = inQ;
    inValid = 1'b1;
    while (!inReady) tick();
    tick();
    inValid = 1'b0;
  endtask

  task automatic fillBlock(input int blk, input int first);
    for (int a = first; a < DEPTH; a++) begin
      if (a == DEPTH - 1)
        check(blockReady == 1'b0, first == 0 ? "R3" : "R8", "blockReady early", blockReady, 0);
      push(blk, a);
    end
    check(blockReady == 1'b1, first == 0 ? "R3" : "R8", "blockReady after block", blockReady, 1);
    check(inReady == 1'b0, "R3", "inReady while full", inReady, 0);
  endtask

  task automatic doRead(input int blk, input int a);
    string tag;
    rdEn = 1'b1;
    rdAddr = AW'(a);
    tick();
    rdEn = 1'b0;
    tag = (blk > 0 && a < OVL) ? "R8" : (a >= DEPTH - OVL) ? "R6" : "R2";
    check(rdValid == 1'b1, "R5", "rdValid after read", rdValid, 1);
    check(rdI == expI[a] && rdQ == expQ[a], tag, $sformatf("data at %0d", a),
          {rdI, rdQ}, {expI[a], expQ[a]});
    if (a >= DEPTH - OVL) begin
      tailI[a - (DEPTH - OVL)] = expI[a];
      tailQ[a - (DEPTH - OVL)] = expQ[a];
    end
  endtask

  task automatic startBlock();
    procStart = 1'b1;
    tick();
    procStart = 1'b0;
    check(blockReady == 1'b0 && inReady == 1'b0, "R4", "flags after start",
          {blockReady, inReady}, 0);
  endtask

  task automatic runCopy();
    int n = 0;
    procDone = 1'b1;
    tick();
    procDone = 1'b0;
    check(inReady == 1'b0, "R7", "inReady at copy start", inReady, 0);
    while (!inReady && n < 1000) begin
      tick();
      n++;
    end
    check(n == OVL, "R7", "copy cycles", n, OVL);
    for (int k = 0; k < OVL; k++) begin
      expI[k] = tailI[k];
      expQ[k] = tailQ[k];
    end
  endtask

  initial begin
    void'($urandom(32'h0C0FFEE5));
    rstN = 1'b0; inValid = 1'b0; procStart = 1'b0; procDone = 1'b0;
    rdEn = 1'b0; rdAddr = '0; inI = '0; inQ = '0;
    repeat (3) tick();
    check(inReady == 0 && blockReady == 0 && rdValid == 0, "R1", "reset outputs",
          {inReady, blockReady, rdValid}, 0);
    rstN = 1'b1;
    check(inReady == 1'b0, "R1", "idle cycle", inReady, 0);
    tick();
    check(inReady == 1'b1, "R1", "ready after idle", inReady, 1);

    // block 0: start pulse mid-fill is ignored
    for (int a = 0; a < 10; a++) push(0, a);
    procStart = 1'b1;
    tick();
    procStart = 1'b0;
    check(inReady == 1'b1, "R4", "start while filling ignored", inReady, 1);
    fillBlock(0, 10);

    // offered junk while full must not be stored
    inValid = 1'b1; inI = '1; inQ = '1;
    repeat (3) tick();
    inValid = 1'b0;
    check(blockReady == 1'b1, "R3", "still full after junk", blockReady, 1);

    // read outside processing
    rdEn = 1'b1; rdAddr = AW'(5);
    tick();
    rdEn = 1'b0;
    check(rdValid == 1'b0, "R5", "read outside processing", rdValid, 0);

    startBlock();
    for (int a = 0; a < DEPTH; a++) doRead(0, a);
    tick();
    runCopy();

    // block 1: random read order
    fillBlock(1, OVL);
    startBlock();
    for (int a = 0; a < DEPTH; a++) order[a] = a;
    for (int a = DEPTH - 1; a > 0; a--) begin
      int j = $urandom_range(0, a);
      int t = order[a];
      order[a] = order[j];
      order[j] = t;
    end
    for (int a = 0; a < DEPTH; a++) doRead(1, order[a]);
    runCopy();

    // block 2: descending read order
    fillBlock(2, OVL);
    startBlock();
    for (int a = DEPTH - 1; a >= 0; a--) doRead(2, a);
    runCopy();

    // block 3: check overlap again after a reversed read
    fillBlock(3, OVL);
    startBlock();
    for (int a = 0; a < OVL; a++) doRead(3, a);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule